// File: doc/BRIEF.md
# ACPI PM1 Sleep Control Register

This block holds the 16-bit power-management control word of an ACPI-style I/O window and turns sleep requests written into it into platform actions. Software writes the control word through a small address/write port. If the written word carries the sleep-enable flag, the block decodes the three-bit sleep type. Type 0 asks for a soft power-off. Type 1 asks for a platform reset, raises a suspend-to-RAM flag that stays set, and hands a set-mask to the owner of the companion PM1 status register. All other types only store the word.

The sleep-enable flag itself is never kept, so reading the word back never shows it. The SCI-enable bit can also be changed by an APM command strobe. A command equal to the enable code sets the bit, a command equal to the disable code clears it, and any other command leaves it alone. Event enables, the PM timer, SCI interrupt generation and the actual power sequencing belong to neighbouring blocks.

Top module: `pm1_sleep_ctrl`

## Requirements
- R1: After reset the control word reads 0x0000, `s3_flag` is 0, and `off_req`, `rst_req` and `sts_set_stb` are 0.
- R2: A write with `io_addr` equal to `CTL_OFS` (default 4) stores `io_wdata` with bit 13 (sleep-enable) forced to 0. A read at `CTL_OFS` returns the stored word, and reads at any other address return 0.
- R3: A write at any address other than `CTL_OFS` changes neither the stored word nor any output.
- R4: A write at `CTL_OFS` with bit 13 set and bits 12:10 equal to 0 makes `off_req` high for exactly the one cycle after the write edge.
- R5: A write at `CTL_OFS` with bit 13 set and bits 12:10 equal to 1 makes `rst_req` and `sts_set_stb` high for the one cycle after the write edge. In that cycle `sts_set_mask` is 0x8100, which is wake status at bit 15 plus power-button status at bit 8. The same write sets `s3_flag`, which then stays at 1 until reset.
- R6: A write at `CTL_OFS` with bit 13 clear, or with bits 12:10 in the range 2 to 7, produces no pulse and leaves `s3_flag` unchanged. `sts_set_mask` is 0 whenever `sts_set_stb` is low.
- R7: When `apm_stb` is high, command `CMD_ON` (default 0xF1) sets bit 0 (SCI enable) and `CMD_OFF` (default 0xF0) clears it. Any other command leaves bit 0 unchanged. If the strobe arrives in the same cycle as a write, the command acts on the newly written word.
- R8: `off_req` and `rst_req` are never high in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| io_addr | input | ADDR_W | Register port byte address |
| io_wr | input | 1 | Write strobe for one cycle |
| io_wdata | input | DW | Write data |
| io_rdata | output | DW | Read data for the addressed register |
| apm_stb | input | 1 | APM command valid for one cycle |
| apm_cmd | input | CMD_W | APM command code |
| off_req | output | 1 | Soft power-off request pulse |
| rst_req | output | 1 | Platform reset request pulse |
| s3_flag | output | 1 | Suspend-to-RAM flag, held until reset |
| sts_set_stb | output | 1 | Strobe to OR the set-mask into the status register |
| sts_set_mask | output | DW | Status bits to set |

## Verification
On every cycle the assertions check the following: the stored word after a write (when no command is pending), the sticky suspend flag, the status mask that accompanies a reset pulse, the exclusion of the two request pulses, and the effect of the enable and disable commands on the SCI bit. Some behaviour can only be shown by the bench's sweeps. These cover the full decode over all eight sleep types with and without sleep-enable, the absence of effects from off-address writes, the cycle in which each pulse falls, and the walk through all 256 command codes in both directions.

// File: rtl/pm1_sleep_ctrl.sv
module pm1_sleep_ctrl #(
  parameter int ADDR_W     = 4,
  parameter int DW         = 16,
  parameter int CMD_W      = 8,
  parameter int CTL_OFS    = 4,
  parameter int SLP_EN_BIT = 13,
  parameter int TYP_LSB    = 10,
  parameter int SCI_BIT    = 0,
  parameter int WAK_BIT    = 15,
  parameter int PWRBTN_BIT = 8,
  parameter logic [CMD_W-1:0] CMD_ON  = 8'hF1,
  parameter logic [CMD_W-1:0] CMD_OFF = 8'hF0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] io_addr,
  input  logic              io_wr,
  input  logic [DW-1:0]     io_wdata,
  output logic [DW-1:0]     io_rdata,
  input  logic              apm_stb,
  input  logic [CMD_W-1:0]  apm_cmd,
  output logic              off_req,
  output logic              rst_req,
  output logic              s3_flag,
  output logic              sts_set_stb,
  output logic [DW-1:0]     sts_set_mask
);
  localparam int TYP_W = 3;
  localparam logic [ADDR_W-1:0] OFS      = CTL_OFS[ADDR_W-1:0];
  localparam logic [DW-1:0]     SLP_MASK = DW'(1) << SLP_EN_BIT;
  localparam logic [DW-1:0]     STS_MASK = (DW'(1) << WAK_BIT) | (DW'(1) << PWRBTN_BIT);

  logic [DW-1:0]    ctl_q, ctl_d;
  logic             hit, go;
  logic [TYP_W-1:0] typ;

  assign hit = io_wr && (io_addr == OFS);
  assign go  = hit && io_wdata[SLP_EN_BIT];
  assign typ = io_wdata[TYP_LSB +: TYP_W];

  always_comb begin
    ctl_d = ctl_q;
    if (hit) ctl_d = io_wdata & ~SLP_MASK;
    if (apm_stb) begin
      if (apm_cmd == CMD_ON)       ctl_d[SCI_BIT] = 1'b1;
      else if (apm_cmd == CMD_OFF) ctl_d[SCI_BIT] = 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ctl_q       <= '0;
      off_req     <= 1'b0;
      rst_req     <= 1'b0;
      s3_flag     <= 1'b0;
      sts_set_stb <= 1'b0;
    end else begin
      ctl_q       <= ctl_d;
      off_req     <= go && (typ == TYP_W'(0));
      rst_req     <= go && (typ == TYP_W'(1));
      sts_set_stb <= go && (typ == TYP_W'(1));
      if (go && (typ == TYP_W'(1))) s3_flag <= 1'b1;
    end
  end

  assign sts_set_mask = sts_set_stb ? STS_MASK : '0;
  assign io_rdata     = (io_addr == OFS) ? ctl_q : '0;

  // R2
  store_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (hit && !apm_stb) |=> (ctl_q == ($past(io_wdata) & ~SLP_MASK)));
  // R4
  off_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (go && typ == TYP_W'(0)) |=> (off_req && !rst_req));
  // R5
  s3_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    s3_flag |=> s3_flag);
  // R5
  rst_sts_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rst_req |-> (sts_set_stb && sts_set_mask == STS_MASK && s3_flag));
  // R7
  apm_on_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (apm_stb && apm_cmd == CMD_ON) |=> ctl_q[SCI_BIT]);
  // R7
  apm_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (apm_stb && apm_cmd == CMD_OFF) |=> !ctl_q[SCI_BIT]);
  // R8
  excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(off_req && rst_req));
endmodule

// File: tb/pm1_sleep_ctrl_test.sv
`timescale 1ns/1ps
module pm1_sleep_ctrl_test;
  logic        clk = 0, rst_n = 0;
  logic [3:0]  io_addr = 0;
  logic        io_wr = 0;
  logic [15:0] io_wdata = 0, io_rdata;
  logic        apm_stb = 0;
  logic [7:0]  apm_cmd = 0;
  logic        off_req, rst_req, s3_flag, sts_set_stb;
  logic [15:0] sts_set_mask;
  int checks = 0, errors = 0;
  logic [15:0] exp_ctl;
  logic        exp_s3;

  always #2 clk = ~clk;

  pm1_sleep_ctrl uut (.clk(clk), .rst_n(rst_n), .io_addr(io_addr), .io_wr(io_wr),
    .io_wdata(io_wdata), .io_rdata(io_rdata), .apm_stb(apm_stb), .apm_cmd(apm_cmd),
    .off_req(off_req), .rst_req(rst_req), .s3_flag(s3_flag),
    .sts_set_stb(sts_set_stb), .sts_set_mask(sts_set_mask));

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic rd_ctl(string req);
    io_addr = 4'd4; #0.1;
    chk(req, {16'h0, io_rdata}, {16'h0, exp_ctl});
  endtask

  task automatic wr(logic [3:0] a, logic [15:0] d);
    @(negedge clk); io_addr = a; io_wdata = d; io_wr = 1;
    @(negedge clk); io_wr = 0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    exp_ctl = 0; exp_s3 = 0;
    rd_ctl("R1 ctl");
    chk("R1 outs", {off_req, rst_req, s3_flag, sts_set_stb}, 0);

    // R4 R5 R6 R2: sweep all sleep types, with and without sleep-enable
    for (int t = 0; t < 8; t++) begin
      for (int se = 0; se < 2; se++) begin
        logic [15:0] d;
        d = 16'h4085 ^ 16'(t * 16'h0111);
        d[12:10] = 3'(t); d[13] = se[0];
        wr(4'd4, d);
        exp_ctl = d & 16'hDFFF;
        if (se == 1 && t == 1) exp_s3 = 1;
        chk("R4 off", off_req, (se == 1 && t == 0));
        chk("R5 rst", {rst_req, sts_set_stb}, (se == 1 && t == 1) ? 2'b11 : 2'b00);
        chk("R5 mask", sts_set_mask, (se == 1 && t == 1) ? 16'h8100 : 16'h0);
        chk("R6 s3", s3_flag, exp_s3);
        rd_ctl("R2 store");
        io_addr = 4'd0; #0.1;
        chk("R2 other addr read", io_rdata, 0);
        @(negedge clk);
        chk("R8 pulses gone", {off_req, rst_req, sts_set_stb}, 0);
      end
    end

    // R3: off-address writes with sleep-enable type 0 and 1
    for (int a = 0; a < 16; a++) begin
      if (a == 4) continue;
      wr(4'(a), 16'h2000 | 16'(a & 1) << 10);
      chk("R3 no pulse", {off_req, rst_req, sts_set_stb}, 0);
      rd_ctl("R3 unchanged");
    end

    // R7: command sweeps both directions
    for (int c = 0; c < 256; c++) begin
      @(negedge clk); apm_cmd = 8'(c); apm_stb = 1;
      @(negedge clk); apm_stb = 0;
      if (c == 8'hF1) exp_ctl[0] = 1; else if (c == 8'hF0) exp_ctl[0] = 0;
      rd_ctl("R7 up");
    end
    for (int c = 255; c >= 0; c--) begin
      @(negedge clk); apm_cmd = 8'(c); apm_stb = 1;
      @(negedge clk); apm_stb = 0;
      if (c == 8'hF1) exp_ctl[0] = 1; else if (c == 8'hF0) exp_ctl[0] = 0;
      rd_ctl("R7 down");
    end

    // R7: command in same cycle as write acts on the new word
    @(negedge clk); io_addr = 4; io_wdata = 16'h0402; io_wr = 1; apm_stb = 1; apm_cmd = 8'hF1;
    @(negedge clk); io_wr = 0; apm_stb = 0;
    exp_ctl = 16'h0403;
    rd_ctl("R7 same cycle");

    // R1: reset clears latched s3 and word
    chk("R5 s3 held", s3_flag, 1);
    rst_n = 0;
    @(negedge clk); rst_n = 1;
    exp_ctl = 0;
    rd_ctl("R1 ctl after reset");
    chk("R1 s3 after reset", s3_flag, 0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule